// File: doc/BRIEF.md
# Two-Master Bus Matrix with Boot Alias

This block is the central interconnect between two bus masters, a processor port (master 0) and a DMA port (master 1), and three slave ports: the nonvolatile memory interface (slave 0), the SRAM (slave 1) and the peripheral bridge (slave 2). Each master port decodes its own address against a fixed memory map and is steered to the matching slave. When both masters target the same slave in the same cycle, a per-slave round-robin arbiter picks one. Masters that target different slaves proceed in parallel.

A 128 KB window at address zero is an alias. A 2-bit select input chooses whether the window shows program flash, system memory or SRAM, and the address is translated before it reaches the slave. Any address that falls outside every memory and peripheral range is refused with a two-cycle error response, and no slave sees it.

The transfer convention is a simplified single-phase AHB style. A master presents NONSEQ or SEQ on its transfer-type input and holds address, control and write data stable until it samples its ready output high. That same cycle carries the read data and the response. Slave ports use the same convention.

Top module: `busmx_top`

## Requirements
- R1: Program flash 0x0800_0000..0x0801_FFFF, data EEPROM 0x0808_0000..0x0808_01FF, system memory 0x1FF0_0000..0x1FF0_1FFF and option bytes 0x1FF8_0000..0x1FF8_007F select slave 0, and the address reaches the slave unchanged.
- R2: 0x2000_0000..0x2000_4FFF selects slave 1 with the address unchanged. The transfer size (byte 0, halfword 1, word 2) is passed through unchanged to whichever slave is selected.
- R3: 0x4000_0000..0x5000_1FFF selects slave 2 with the address unchanged.
- R4: An address A below 0x0002_0000 is aliased according to `remap_sel`:
  - 2'b01 selects slave 0 at 0x1FF0_0000+A, and only for A < 0x2000.
  - 2'b11 selects slave 1 at 0x2000_0000+A, and only for A < 0x5000.
  - Any value with bit 0 clear selects slave 0 at 0x0800_0000+A.
  - Offsets beyond the chosen memory count as reserved.
- R5: A request to any other (reserved) address selects no slave. The master sees ready low with the error response high for one cycle, then ready high with the error response high.
- R6: When both masters request an idle slave in the same cycle, the one named by that slave's round-robin pointer is granted. After reset every pointer names the processor.
- R7: Each transfer that completes on a slave moves that slave's pointer to the other master, so under continuous contention the grants alternate.
- R8: A master requesting a slave that it does not own sees ready low and the response low. A granted transfer keeps the slave, with the slave select held, while the slave holds its ready low.
- R9: Two masters that target different slaves are both granted, and they can complete in the same cycle.
- R10: An idle master (transfer type IDLE or BUSY) sees ready high and the response low, including during reset. A slave that no master requests has its select low.
- R11: The granted master's write flag and write data reach the slave. The slave's read data, ready and response reach the granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| remap_sel | input | 2 | Alias select for the window at address zero |
| m_htrans | input | 2x2 | Transfer type per master (bit 1 set = request) |
| m_haddr | input | 2x32 | Address per master |
| m_hwrite | input | 2 | Write flag per master |
| m_hsize | input | 2x3 | Transfer size per master |
| m_hwdata | input | 2xDW | Write data per master |
| m_hrdata | output | 2xDW | Read data per master |
| m_hready | output | 2 | Transfer done per master |
| m_hresp | output | 2 | Error response per master |
| s_hsel | output | 3 | Select per slave |
| s_haddr | output | 3x32 | Translated address per slave |
| s_hwrite | output | 3 | Write flag per slave |
| s_hsize | output | 3x3 | Transfer size per slave |
| s_hwdata | output | 3xDW | Write data per slave |
| s_hrdata | input | 3xDW | Read data per slave |
| s_hready | input | 3 | Transfer done per slave |
| s_hresp | input | 3 | Error response per slave |

## Verification
The bench targets the edges of every range and the alias limits for each select value. For example, 0x0000_1FFC with system memory aliased must be served, while 0x0000_2000 must be refused. A decoder with an off-by-one limit would route such an address to a memory, or flag a valid one as an error.

Contention runs check that the processor wins first after reset and that grants then alternate strictly, including while the slave inserts wait states. An arbiter that re-arbitrated mid-transfer would switch the select during a wait, and a stuck pointer would starve the DMA.

Parallel traffic to different slaves must finish in the same cycle. Reserved addresses must produce exactly one low-ready error cycle. A merged arbiter would serialise the parallel traffic, and a one-cycle error path would raise ready too early.

// File: rtl/busmx_pkg.sv
// Shared types and the fixed memory map of the two-master bus matrix.
// Assumes exactly two masters (0 = processor, 1 = DMA) and three slaves.
package busmx_pkg;

    localparam int AW      = 32;
    localparam int NUM_MST = 2;
    localparam int NUM_SLV = 3;

    typedef enum logic [1:0] {
        TGT_NVM  = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_PERI = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e          tgt;
        logic [AW-1:0] xaddr;
    } route_t;

    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    localparam logic [1:0] ALIAS_SYSMEM = 2'b01;
    localparam logic [1:0] ALIAS_SRAM   = 2'b11;

    localparam logic [AW-1:0] FLASH_BASE  = 32'h0800_0000;
    localparam logic [AW-1:0] EEPROM_BASE = 32'h0808_0000;
    localparam logic [AW-1:0] SYSMEM_BASE = 32'h1FF0_0000;
    localparam logic [AW-1:0] OPTB_BASE   = 32'h1FF8_0000;
    localparam logic [AW-1:0] SRAM_BASE   = 32'h2000_0000;
    localparam logic [AW-1:0] PERI_FIRST  = 32'h4000_0000;
    localparam logic [AW-1:0] PERI_LAST   = 32'h5000_1FFF;

    // True when addr lies in [base, base+bytes).
    function automatic logic in_window(input logic [AW-1:0] addr,
                                       input logic [AW-1:0] base,
                                       input logic [AW-1:0] bytes);
        return (addr >= base) && ((addr - base) < bytes);
    endfunction

endpackage

// File: rtl/busmx_decoder.sv
// Address decoder for one master port.
// Maps an address to a slave and a translated address, applying the
// alias window at zero. Purely combinational; remap_sel is assumed
// stable while a transfer is outstanding.
module busmx_decoder
    import busmx_pkg::*;
#(
    parameter int FLASH_BYTES  = 131072,
    parameter int EEPROM_BYTES = 512,
    parameter int SYSMEM_BYTES = 8192,
    parameter int OPTB_BYTES   = 128,
    parameter int SRAM_BYTES   = 20480,
    parameter int ALIAS_BYTES  = FLASH_BYTES
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    remap_sel,
    output route_t        route
);

    localparam logic [AW-1:0] FLASH_SZ  = AW'(FLASH_BYTES);
    localparam logic [AW-1:0] EEPROM_SZ = AW'(EEPROM_BYTES);
    localparam logic [AW-1:0] SYSMEM_SZ = AW'(SYSMEM_BYTES);
    localparam logic [AW-1:0] OPTB_SZ   = AW'(OPTB_BYTES);
    localparam logic [AW-1:0] SRAM_SZ   = AW'(SRAM_BYTES);
    localparam logic [AW-1:0] ALIAS_SZ  = AW'(ALIAS_BYTES);

    logic [AW-1:0] alias_base;
    logic [AW-1:0] alias_limit;
    tgt_e          alias_tgt;

    // Pick the memory that the alias window currently shows.
    always_comb begin
        case (remap_sel)
            ALIAS_SYSMEM: begin
                alias_base  = SYSMEM_BASE;
                alias_limit = SYSMEM_SZ;
                alias_tgt   = TGT_NVM;
            end
            ALIAS_SRAM: begin
                alias_base  = SRAM_BASE;
                alias_limit = SRAM_SZ;
                alias_tgt   = TGT_SRAM;
            end
            default: begin
                alias_base  = FLASH_BASE;
                alias_limit = FLASH_SZ;
                alias_tgt   = TGT_NVM;
            end
        endcase
    end

    // Resolve the target slave and the address it will see.
    always_comb begin
        route.tgt   = TGT_NONE;
        route.xaddr = addr;
        if (addr < ALIAS_SZ) begin
            if (addr < alias_limit) begin
                route.tgt   = alias_tgt;
                route.xaddr = alias_base + addr;
            end
        end else if (in_window(addr, FLASH_BASE, FLASH_SZ)   ||
                     in_window(addr, EEPROM_BASE, EEPROM_SZ) ||
                     in_window(addr, SYSMEM_BASE, SYSMEM_SZ) ||
                     in_window(addr, OPTB_BASE, OPTB_SZ)) begin
            route.tgt = TGT_NVM;
        end else if (in_window(addr, SRAM_BASE, SRAM_SZ)) begin
            route.tgt = TGT_SRAM;
        end else if ((addr >= PERI_FIRST) && (addr <= PERI_LAST)) begin
            route.tgt = TGT_PERI;
        end
    end

endmodule

// File: rtl/busmx_arbiter.sv
// Round-robin arbiter for one slave port shared by the two masters.
// Holds the grant while the slave stretches a transfer, and hands
// priority to the other master when a transfer completes. Assumes a
// requesting master keeps its request until it is served.
module busmx_arbiter
    import busmx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req,
    input  logic               slv_ready,
    output logic [NUM_MST-1:0] gnt,
    output logic               gnt_idx,
    output logic               prio
);

    logic lock_vld;
    logic lock_idx;
    logic gnt_vld;

    // Choose the owner for this cycle: the locked one, else by priority.
    always_comb begin
        gnt_idx = prio;
        gnt_vld = 1'b0;
        if (lock_vld) begin
            gnt_idx = lock_idx;
            gnt_vld = req[lock_idx];
        end else if (&req) begin
            gnt_idx = prio;
            gnt_vld = 1'b1;
        end else if (req[0]) begin
            gnt_idx = 1'b0;
            gnt_vld = 1'b1;
        end else if (req[1]) begin
            gnt_idx = 1'b1;
            gnt_vld = 1'b1;
        end
        gnt = gnt_vld ? (NUM_MST'(1) << gnt_idx) : '0;
    end

    // Track the lock during wait states and rotate priority on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld <= 1'b0;
            lock_idx <= 1'b0;
            prio     <= 1'b0;
        end else if (gnt_vld && slv_ready) begin
            lock_vld <= 1'b0;
            prio     <= ~gnt_idx;
        end else if (gnt_vld) begin
            lock_vld <= 1'b1;
            lock_idx <= gnt_idx;
        end
    end

endmodule

// File: rtl/busmx_errresp.sv
// Error responder for one master port.
// Produces a two-cycle error response for a request that decodes to no
// slave. Assumes the master holds the request across both cycles.
module busmx_errresp (
    input  logic clk,
    input  logic rst_n,
    input  logic bad,
    output logic err_ready,
    output logic err_resp
);

    logic second;

    // Ready is low in the first error cycle and high in the second.
    always_comb begin
        err_resp  = bad;
        err_ready = bad && second;
    end

    // Remember that the first error cycle has been shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second <= 1'b0;
        end else begin
            second <= bad && !second;
        end
    end

endmodule

// File: rtl/busmx_top.sv
// Two-master, three-slave bus matrix.
// Each master port has a decoder and an error responder; each slave
// port has its own round-robin arbiter, so masters aimed at different
// slaves run in parallel. Single-phase handshake: a master holds its
// request until it samples m_hready high.
module busmx_top
    import busmx_pkg::*;
#(
    parameter int DW           = 32,
    parameter int FLASH_BYTES  = 131072,
    parameter int EEPROM_BYTES = 512,
    parameter int SYSMEM_BYTES = 8192,
    parameter int OPTB_BYTES   = 128,
    parameter int SRAM_BYTES   = 20480,
    parameter int ALIAS_BYTES  = FLASH_BYTES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    remap_sel,
    input  logic [NUM_MST-1:0][1:0]       m_htrans,
    input  logic [NUM_MST-1:0][AW-1:0]    m_haddr,
    input  logic [NUM_MST-1:0]            m_hwrite,
    input  logic [NUM_MST-1:0][2:0]       m_hsize,
    input  logic [NUM_MST-1:0][DW-1:0]    m_hwdata,
    output logic [NUM_MST-1:0][DW-1:0]    m_hrdata,
    output logic [NUM_MST-1:0]            m_hready,
    output logic [NUM_MST-1:0]            m_hresp,
    output logic [NUM_SLV-1:0]            s_hsel,
    output logic [NUM_SLV-1:0][AW-1:0]    s_haddr,
    output logic [NUM_SLV-1:0]            s_hwrite,
    output logic [NUM_SLV-1:0][2:0]       s_hsize,
    output logic [NUM_SLV-1:0][DW-1:0]    s_hwdata,
    input  logic [NUM_SLV-1:0][DW-1:0]    s_hrdata,
    input  logic [NUM_SLV-1:0]            s_hready,
    input  logic [NUM_SLV-1:0]            s_hresp
);

    route_t                            rt [NUM_MST];
    logic [NUM_MST-1:0]                mreq;
    logic [NUM_MST-1:0]                bad;
    logic [NUM_MST-1:0]                err_rdy;
    logic [NUM_MST-1:0]                err_rsp;
    logic [NUM_SLV-1:0][NUM_MST-1:0]   sreq;
    logic [NUM_SLV-1:0][NUM_MST-1:0]   slv_gnt;
    logic [NUM_SLV-1:0]                slv_gidx;
    logic [NUM_SLV-1:0]                slv_prio;

    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        // Classify the master's transfer type as a request or not.
        always_comb begin
            mreq[m] = (m_htrans[m] == HT_NONSEQ) || (m_htrans[m] == HT_SEQ);
            bad[m]  = mreq[m] && (rt[m].tgt == TGT_NONE);
        end

        busmx_decoder #(
            .FLASH_BYTES  (FLASH_BYTES),
            .EEPROM_BYTES (EEPROM_BYTES),
            .SYSMEM_BYTES (SYSMEM_BYTES),
            .OPTB_BYTES   (OPTB_BYTES),
            .SRAM_BYTES   (SRAM_BYTES),
            .ALIAS_BYTES  (ALIAS_BYTES)
        ) u_dec (
            .addr      (m_haddr[m]),
            .remap_sel (remap_sel),
            .route     (rt[m])
        );

        busmx_errresp u_err (
            .clk       (clk),
            .rst_n     (rst_n),
            .bad       (bad[m]),
            .err_ready (err_rdy[m]),
            .err_resp  (err_rsp[m])
        );

        // Return path: error, granted slave, waiting, or idle.
        always_comb begin
            logic [1:0] sidx;
            sidx        = 2'(rt[m].tgt);
            m_hready[m] = 1'b1;
            m_hresp[m]  = 1'b0;
            m_hrdata[m] = '0;
            if (bad[m]) begin
                m_hready[m] = err_rdy[m];
                m_hresp[m]  = err_rsp[m];
            end else if (mreq[m]) begin
                m_hready[m] = slv_gnt[sidx][m] && s_hready[sidx];
                m_hresp[m]  = slv_gnt[sidx][m] && s_hresp[sidx];
                m_hrdata[m] = s_hrdata[sidx];
            end
        end
    end

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        // Collect the masters that aim at this slave.
        always_comb begin
            for (int m = 0; m < NUM_MST; m++) begin
                sreq[s][m] = mreq[m] && (rt[m].tgt == tgt_e'(2'(s)));
            end
        end

        busmx_arbiter u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (sreq[s]),
            .slv_ready (s_hready[s]),
            .gnt       (slv_gnt[s]),
            .gnt_idx   (slv_gidx[s]),
            .prio      (slv_prio[s])
        );

        // Forward the owner's address phase and write data to the slave.
        always_comb begin
            s_hsel[s]   = |slv_gnt[s];
            s_haddr[s]  = rt[slv_gidx[s]].xaddr;
            s_hwrite[s] = m_hwrite[slv_gidx[s]];
            s_hsize[s]  = m_hsize[slv_gidx[s]];
            s_hwdata[s] = m_hwdata[slv_gidx[s]];
        end
    end

endmodule

// File: rtl/busmx_checker.sv
// Protocol checker for busmx_top, attached by bind. It observes the
// ports plus the per-slave grant and priority signals of the arbiters.
module busmx_checker
    import busmx_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_MST-1:0][1:0]     m_htrans,
    input logic [NUM_MST-1:0]          m_hready,
    input logic [NUM_MST-1:0]          m_hresp,
    input logic [NUM_SLV-1:0]          s_hsel,
    input logic [NUM_SLV-1:0]          s_hready,
    input logic [NUM_SLV-1:0][AW-1:0]  s_haddr,
    input logic [NUM_SLV-1:0][NUM_MST-1:0] slv_gnt,
    input logic [NUM_SLV-1:0]          slv_prio
);

    for (genvar m = 0; m < NUM_MST; m++) begin : g_m
        assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !m_htrans[m][1] |-> (m_hready[m] && !m_hresp[m]));

        assert_error_two_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (m_htrans[m][1] && m_hresp[m] && !m_hready[m]) |=> (m_hready[m] && m_hresp[m]));
    end

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_s
        assert_sel_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
            s_hsel[s] |-> (m_htrans[0][1] || m_htrans[1][1]));

        assert_hold_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_hsel[s] && !s_hready[s]) |=>
                (s_hsel[s] && $stable(slv_gnt[s]) && $stable(s_haddr[s])));

        assert_rr_to_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (slv_gnt[s][0] && s_hready[s]) |=> slv_prio[s]);

        assert_rr_to_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (slv_gnt[s][1] && s_hready[s]) |=> !slv_prio[s]);
    end

endmodule

bind busmx_top busmx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_htrans (m_htrans),
    .m_hready (m_hready),
    .m_hresp  (m_hresp),
    .s_hsel   (s_hsel),
    .s_hready (s_hready),
    .s_haddr  (s_haddr),
    .slv_gnt  (slv_gnt),
    .slv_prio (slv_prio)
);

// File: tb/tb_busmx_top.sv
// Self-checking bench: behavioural reference model compared every cycle.
module tb_busmx_top;

    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]  remap_sel = 2'b00;
    logic [1:0]  tr [2];
    logic [31:0] ad [2];
    logic        wr [2];
    logic [2:0]  sz [2];
    logic [31:0] wd [2];

    logic [1:0][1:0]    m_htrans;
    logic [1:0][31:0]   m_haddr;
    logic [1:0]         m_hwrite;
    logic [1:0][2:0]    m_hsize;
    logic [1:0][DW-1:0] m_hwdata;
    logic [1:0][DW-1:0] m_hrdata;
    logic [1:0]         m_hready, m_hresp;
    logic [2:0]         s_hsel;
    logic [2:0][31:0]   s_haddr;
    logic [2:0]         s_hwrite;
    logic [2:0][2:0]    s_hsize;
    logic [2:0][DW-1:0] s_hwdata;
    logic [2:0][DW-1:0] s_hrdata;
    logic [2:0]         s_hready;
    logic [2:0]         s_hresp;

    assign m_htrans = {tr[1], tr[0]};
    assign m_haddr  = {ad[1], ad[0]};
    assign m_hwrite = {wr[1], wr[0]};
    assign m_hsize  = {sz[1], sz[0]};
    assign m_hwdata = {wd[1], wd[0]};

    busmx_top dut (
        .clk(clk), .rst_n(rst_n), .remap_sel(remap_sel),
        .m_htrans(m_htrans), .m_haddr(m_haddr), .m_hwrite(m_hwrite),
        .m_hsize(m_hsize), .m_hwdata(m_hwdata), .m_hrdata(m_hrdata),
        .m_hready(m_hready), .m_hresp(m_hresp),
        .s_hsel(s_hsel), .s_haddr(s_haddr), .s_hwrite(s_hwrite),
        .s_hsize(s_hsize), .s_hwdata(s_hwdata), .s_hrdata(s_hrdata),
        .s_hready(s_hready), .s_hresp(s_hresp)
    );

    // Slave responders: programmable wait states, data derived from address.
    int wcfg [3];
    int wcnt [3];
    function automatic logic [31:0] pat(input int k, input logic [31:0] a);
        return a ^ (32'h5A00_0000 + 32'(k));
    endfunction
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            s_hready[k] = (wcnt[k] >= wcfg[k]);
            s_hrdata[k] = pat(k, s_haddr[k]);
            s_hresp[k]  = 1'b0;
        end
    end
    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (!rst_n || !s_hsel[k] || s_hready[k]) wcnt[k] <= 0;
            else wcnt[k] <= wcnt[k] + 1;
        end
    end

    int n_chk = 0;
    int n_err = 0;
    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Reference address map written from the requirements.
    function automatic void ref_route(input logic [31:0] a, input logic [1:0] rm,
                                      output int t, output logic [31:0] x);
        t = 3; x = a;
        if (a < 32'h0002_0000) begin
            if (rm == 2'b11) begin
                if (a < 32'h5000) begin t = 1; x = 32'h2000_0000 + a; end
            end else if (rm == 2'b01) begin
                if (a < 32'h2000) begin t = 0; x = 32'h1FF0_0000 + a; end
            end else begin
                t = 0; x = 32'h0800_0000 + a;
            end
        end
        else if (a >= 32'h0800_0000 && a <= 32'h0801_FFFF) t = 0;
        else if (a >= 32'h0808_0000 && a <= 32'h0808_01FF) t = 0;
        else if (a >= 32'h1FF0_0000 && a <= 32'h1FF0_1FFF) t = 0;
        else if (a >= 32'h1FF8_0000 && a <= 32'h1FF8_007F) t = 0;
        else if (a >= 32'h2000_0000 && a <= 32'h2000_4FFF) t = 1;
        else if (a >= 32'h4000_0000 && a <= 32'h5000_1FFF) t = 2;
    endfunction

    // Reference model state.
    int own [3];
    int ptr [3];
    bit errph [2];
    int log_q [3][$];
    int par_cnt = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                own[k] = -1; ptr[k] = 0;
                chk("R10", "reset s_hsel", 32'(s_hsel[k]), 32'd0);
            end
            for (int m = 0; m < 2; m++) begin
                errph[m] = 1'b0;
                chk("R10", "reset m_hready", 32'(m_hready[m]), 32'd1);
            end
        end else begin
            int t [2];
            logic [31:0] x [2];
            bit rq [2];
            int g [3];
            string tg;
            for (int m = 0; m < 2; m++) begin
                rq[m] = tr[m][1];
                ref_route(ad[m], remap_sel, t[m], x[m]);
            end
            for (int s = 0; s < 3; s++) begin
                bit r0, r1;
                r0 = rq[0] && t[0] == s;
                r1 = rq[1] && t[1] == s;
                if (own[s] >= 0) g[s] = own[s];
                else if (r0 && r1) g[s] = ptr[s];
                else if (r0) g[s] = 0;
                else if (r1) g[s] = 1;
                else g[s] = -1;
                if (r0 && r1) tg = "R6";
                else if (g[s] < 0) tg = "R10";
                else tg = (s == 0) ? "R1" : (s == 1) ? "R2" : "R3";
                chk(tg, $sformatf("s_hsel[%0d]", s), 32'(s_hsel[s]), 32'(g[s] >= 0));
                if (g[s] >= 0) begin
                    if (ad[g[s]] < 32'h0002_0000) tg = "R4";
                    chk(tg, $sformatf("s_haddr[%0d]", s), s_haddr[s], x[g[s]]);
                    chk("R2", "s_hsize", 32'(s_hsize[s]), 32'(sz[g[s]]));
                    chk("R11", "s_hwrite", 32'(s_hwrite[s]), 32'(wr[g[s]]));
                    if (wr[g[s]]) chk("R11", "s_hwdata", s_hwdata[s], wd[g[s]]);
                end
            end
            for (int m = 0; m < 2; m++) begin
                if (!rq[m]) begin
                    chk("R10", "idle m_hready", 32'(m_hready[m]), 32'd1);
                    chk("R10", "idle m_hresp", 32'(m_hresp[m]), 32'd0);
                end else if (t[m] == 3) begin
                    chk("R5", "error m_hready", 32'(m_hready[m]), 32'(errph[m]));
                    chk("R5", "error m_hresp", 32'(m_hresp[m]), 32'd1);
                end else if (g[t[m]] == m) begin
                    chk("R11", "granted m_hready", 32'(m_hready[m]), 32'(s_hready[t[m]]));
                    chk("R11", "granted m_hresp", 32'(m_hresp[m]), 32'd0);
                    if (s_hready[t[m]] && !wr[m])
                        chk("R11", "m_hrdata", m_hrdata[m], pat(t[m], x[m]));
                end else begin
                    chk("R8", "waiting m_hready", 32'(m_hready[m]), 32'd0);
                    chk("R8", "waiting m_hresp", 32'(m_hresp[m]), 32'd0);
                end
            end
            if (rq[0] && rq[1] && t[0] < 3 && t[1] < 3 && t[0] != t[1] &&
                m_hready[0] && m_hready[1]) par_cnt++;
            for (int m = 0; m < 2; m++) errph[m] = rq[m] && t[m] == 3 && !errph[m];
            for (int s = 0; s < 3; s++) begin
                if (g[s] >= 0) begin
                    if (s_hready[s]) begin
                        own[s] = -1; ptr[s] = 1 - g[s]; log_q[s].push_back(g[s]);
                    end else own[s] = g[s];
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    // One transfer on master m; call just after a rising edge.
    task automatic xfer(input int m, input logic [31:0] a, input bit w,
                        input logic [2:0] s, input logic [31:0] d);
        bit ok;
        tr[m] = 2'b10; ad[m] = a; wr[m] = w; sz[m] = s; wd[m] = d;
        do begin
            @(negedge clk); ok = m_hready[m];
            @(posedge clk); #1;
        end while (!ok);
        tr[m] = 2'b00;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] pick(input int k, input logic [31:0] off);
        case (k)
            0: return 32'h0800_0000 + off;   1: return 32'h0801_FFFC;
            2: return 32'h0808_0000 + (off & 32'h1FC);
            3: return 32'h1FF0_0000 + off;   4: return 32'h1FF8_007C;
            5: return 32'h2000_0000 + off;   6: return 32'h2000_4FFC;
            7: return 32'h4000_0000 + off;   8: return 32'h5000_1FFC;
            9: return off;                   10: return 32'h0000_1FFC;
            11: return 32'h0000_4FFC;        12: return 32'h3000_0000;
            13: return 32'h0802_0000;        14: return 32'h5000_2000;
            default: return 32'h2000_5000;
        endcase
    endfunction

    initial begin
        for (int m = 0; m < 2; m++) begin
            tr[m] = 2'b00; ad[m] = '0; wr[m] = 1'b0; sz[m] = 3'd2; wd[m] = '0;
        end
        for (int k = 0; k < 3; k++) wcfg[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R6: first contention after reset goes to the processor; R7 alternation.
        fork
            for (int i = 0; i < 4; i++) xfer(0, 32'h2000_0100 + 32'(4*i), 1'b1, 3'd2, 32'hC0DE_0000 + 32'(i));
            for (int i = 0; i < 4; i++) xfer(1, 32'h2000_0200 + 32'(4*i), 1'b0, 3'd2, 32'h0);
        join
        chk("R6", "first SRAM winner", 32'(log_q[1][0]), 32'd0);
        for (int i = 1; i < log_q[1].size(); i++)
            chk("R7", "SRAM alternation", 32'(log_q[1][i] != log_q[1][i-1]), 32'd1);

        // R8 and R7 with wait states on the nonvolatile slave.
        gap(1);
        wcfg[0] = 2;
        log_q[0].delete();
        fork
            for (int i = 0; i < 3; i++) xfer(0, 32'h0800_0040 + 32'(4*i), 1'b0, 3'd2, 32'h0);
            for (int i = 0; i < 3; i++) xfer(1, 32'h0808_0010 + 32'(4*i), 1'b1, 3'd1, 32'h1234_5678);
        join
        for (int i = 1; i < log_q[0].size(); i++)
            chk("R7", "NVM alternation under waits", 32'(log_q[0][i] != log_q[0][i-1]), 32'd1);
        wcfg[0] = 0;

        // R1 R2 R3: single-master map coverage, range edges.
        xfer(0, 32'h0801_FFFC, 1'b0, 3'd2, 0);
        xfer(0, 32'h0808_01FC, 1'b1, 3'd2, 32'hAAAA_5555);
        xfer(0, 32'h1FF0_1FFC, 1'b0, 3'd2, 0);
        xfer(0, 32'h1FF8_007C, 1'b0, 3'd2, 0);
        xfer(1, 32'h2000_4FFF, 1'b1, 3'd0, 32'h0000_00EE);
        xfer(1, 32'h2000_0002, 1'b0, 3'd1, 0);
        xfer(0, 32'h4000_0000, 1'b1, 3'd2, 32'h0BAD_F00D);
        xfer(1, 32'h5000_1FFC, 1'b0, 3'd2, 0);

        // R4: alias window under each select value.
        remap_sel = 2'b00; xfer(0, 32'h0001_FFFC, 1'b0, 3'd2, 0);
        remap_sel = 2'b01; xfer(0, 32'h0000_1FFC, 1'b0, 3'd2, 0);
        xfer(0, 32'h0000_2000, 1'b0, 3'd2, 0);
        remap_sel = 2'b11; xfer(1, 32'h0000_4FFC, 1'b1, 3'd2, 32'h7777_1111);
        xfer(0, 32'h0000_5000, 1'b0, 3'd2, 0);
        remap_sel = 2'b10; xfer(0, 32'h0000_0100, 1'b0, 3'd2, 0);
        remap_sel = 2'b00;

        // R5: reserved addresses on both masters.
        xfer(0, 32'h0802_0000, 1'b0, 3'd2, 0);
        xfer(1, 32'h2000_5000, 1'b1, 3'd2, 32'h1);
        xfer(0, 32'h3000_0000, 1'b0, 3'd2, 0);
        xfer(1, 32'h5000_2000, 1'b0, 3'd2, 0);
        xfer(0, 32'hE000_0000, 1'b0, 3'd2, 0);

        // R9: different slaves complete together; error beside a valid access.
        par_cnt = 0;
        fork
            xfer(0, 32'h0800_0000, 1'b0, 3'd2, 0);
            xfer(1, 32'h4000_1000, 1'b1, 3'd2, 32'h5555_AAAA);
        join
        chk("R9", "parallel completion count", 32'(par_cnt > 0), 32'd1);
        fork
            xfer(0, 32'h6000_0000, 1'b0, 3'd2, 0);
            xfer(1, 32'h2000_0010, 1'b0, 3'd2, 0);
        join

        // Mixed traffic with random waits and remap values.
        for (int it = 0; it < 300; it++) begin
            for (int k = 0; k < 3; k++) wcfg[k] = $urandom_range(0, 3);
            remap_sel = 2'($urandom_range(0, 3));
            fork
                begin
                    gap($urandom_range(0, 1));
                    xfer(0, pick($urandom_range(0, 15), 32'($urandom_range(0, 1023)) << 2),
                         1'($urandom_range(0, 1)), 3'd2, $urandom);
                end
                begin
                    gap($urandom_range(0, 1));
                    xfer(1, pick($urandom_range(0, 15), 32'($urandom_range(0, 1023)) << 2),
                         1'($urandom_range(0, 1)), 3'($urandom_range(0, 2)), $urandom);
                end
            join
        end

        gap(2);
        report();
    end

endmodule